// File: doc/BRIEF.md
# Keyed Windowed Watchdog

A 32-bit watchdog that counts down from a programmed period and must be reloaded by software before it expires. A reload takes two key words written in order to a key register. When window mode is on, the keys are accepted only once the count has fallen below a programmed window limit. A key written while the window is closed is treated as a misuse. It produces either a one-cycle bus error or a reset request, depending on a control bit.

On expiry the block either requests reset at once or, in interrupt-first mode, raises an interrupt flag and starts a fresh period. A second expiry while the flag is still pending then requests reset. Counting advances only on cycles where a count-enable strobe is high. This lets a slower time base be fed in without a second clock. A strap input decides whether the watchdog is already running when reset is released.

Register map (word addresses on a 3-bit bus): 0 control (bit 0 run, bit 1 window mode, bit 2 misuse-resets, bit 3 interrupt-first), 1 period, 2 window limit, 3 key (bits 15:0), 4 interrupt flag (bit 0), 5 live count (read-only).

Top module: `keyed_wdog`

## Requirements
- R1: After reset, control bit 0 equals `en_strap`, and the count register holds the clamped reset period. With the strap high, the count falls on every enabled cycle from release onward, with no register write needed.
- R2: Any period value below 0x100 is loaded into the counter as exactly 0x100.
- R3: The counter is loaded with the effective period in two cases: on the write that turns control bit 0 from 0 to 1, and on every accepted service sequence. Any read after that write returns the new value.
- R4: While running, the counter falls by one on each clock with `cnt_en` high. With `cnt_en` low, or with control bit 0 clear, it holds its value.
- R5: A service sequence is key 0xA602 followed later by key 0xB480, written to address 3 bits 15:0. Any number of idle cycles may separate the two keys.
- R6: Keys 0xC520 and 0xD928 leave a half-done sequence untouched. Any other non-service key cancels it. Writing 0xA602 arms the sequence, and re-arms it if already armed. Writing 0xB480 when not armed does nothing.
- R7: With control bits 0 and 1 both set, a write of 0xA602 or 0xB480 takes effect only while the count is below the window register at address 2.
- R8: A service key written while the window is closed changes neither the counter nor the sequence. If control bit 2 is clear, `bus_err` is high for the one cycle after the write. If bit 2 is set, `rst_req` is asserted.
- R9: An expiry is an enabled `cnt_en` cycle on which the count is already 0. With control bit 3 clear, `rst_req` rises on that edge, so it is high 0x101 ticks after a load of 0x100. It stays high until `rst_n` is asserted.
- R10: With control bit 3 set, an expiry with the flag clear sets the flag (`irq`) and reloads the period. An expiry with the flag already set asserts `rst_req`.
- R11: The flag reads at address 4 bit 0. Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged.
- R12: Address 5 returns the live count, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_strap | input | 1 | Reset value of the run bit |
| cnt_en | input | 1 | Count-enable strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| bus_err | output | 1 | One-cycle error for a closed-window key write |
| irq | output | 1 | Interrupt flag |
| rst_req | output | 1 | Sticky reset request |

## Verification
The bench keeps the 32-bit width and the 0x100 minimum period. With that minimum, every expiry lands about 257 ticks after a load, so exact expiry cycles and double timeouts stay short. It sets the reset period to 0x300, above the minimum, so the strap-start count is distinguishable from a clamped value. It also holds `cnt_en` low around key writes, which freezes the count and turns every reload-or-not outcome into an exact value.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

    localparam int ADDR_W = 3;
    localparam int KEY_W  = 16;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_TMO  = 3'd1,
        A_WIN  = 3'd2,
        A_KEY  = 3'd3,
        A_FLAG = 3'd4,
        A_CNT  = 3'd5
    } wd_addr_e;

    localparam logic [KEY_W-1:0] KEY_ARM  = 16'hA602;
    localparam logic [KEY_W-1:0] KEY_FIRE = 16'hB480;
    localparam logic [KEY_W-1:0] KEY_UL_A = 16'hC520;
    localparam logic [KEY_W-1:0] KEY_UL_B = 16'hD928;

    // bit 0 run, bit 1 window mode, bit 2 misuse resets, bit 3 irq first
    typedef struct packed {
        logic irq_first;
        logic inv_rst;
        logic win_mode;
        logic en;
    } wd_ctrl_t;

endpackage

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
    import keyed_wdog_pkg::*;
#(
    parameter int              W      = 32,
    parameter logic [W-1:0]    TO_RST = 32'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_strap,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      count,
    input  logic              irq,
    output logic [W-1:0]      bus_rdata,
    output wd_ctrl_t          ctrl,
    output logic [W-1:0]      tmo,
    output logic [W-1:0]      win,
    output logic              key_wr,
    output logic [KEY_W-1:0]  key_val,
    output logic              en_rise,
    output logic              flag_clr
);

    typedef struct packed {
        wd_ctrl_t     ctrl;
        logic [W-1:0] tmo;
        logic [W-1:0] win;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        key_wr   = 1'b0;
        en_rise  = 1'b0;
        flag_clr = 1'b0;
        key_val  = bus_wdata[KEY_W-1:0];
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL: begin
                    r_d.ctrl = wd_ctrl_t'(bus_wdata[3:0]);
                    en_rise  = bus_wdata[0] && !r_q.ctrl.en;
                end
                A_TMO:  r_d.tmo = bus_wdata;
                A_WIN:  r_d.win = bus_wdata;
                A_KEY:  key_wr = 1'b1;
                A_FLAG: flag_clr = bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl <= '{irq_first: 1'b0, inv_rst: 1'b0, win_mode: 1'b0, en: en_strap};
            r_q.tmo  <= TO_RST;
            r_q.win  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {{(W-4){1'b0}}, r_q.ctrl};
            A_TMO:   bus_rdata = r_q.tmo;
            A_WIN:   bus_rdata = r_q.win;
            A_FLAG:  bus_rdata = {{(W-1){1'b0}}, irq};
            A_CNT:   bus_rdata = count;
            default: bus_rdata = '0;
        endcase
    end

    assign ctrl = r_q.ctrl;
    assign tmo  = r_q.tmo;
    assign win  = r_q.win;

    // R1: the run bit only changes through a control write
    p_run_bit_by_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_CTRL) |=> $stable(ctrl.en));

endmodule

// File: rtl/keyed_wdog_keyseq.sv
module keyed_wdog_keyseq
    import keyed_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             gate_closed,
    output logic             svc_ok,
    output logic             svc_bad
);

    logic armed_d, armed_q;
    logic is_svc, is_unlock;

    always_comb begin
        armed_d   = armed_q;
        svc_ok    = 1'b0;
        svc_bad   = 1'b0;
        is_svc    = (key_val == KEY_ARM) || (key_val == KEY_FIRE);
        is_unlock = (key_val == KEY_UL_A) || (key_val == KEY_UL_B);
        if (key_wr) begin
            if (is_svc && gate_closed) begin
                svc_bad = 1'b1;
            end else if (key_val == KEY_ARM) begin
                armed_d = 1'b1;
            end else if (key_val == KEY_FIRE) begin
                svc_ok  = armed_q;
                armed_d = 1'b0;
            end else if (!is_unlock) begin
                armed_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    // R5: an accepted sequence leaves nothing armed
    p_disarm_after_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> !armed_q);

    // R8: a rejected key leaves the sequence state untouched
    p_bad_keeps_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        svc_bad |=> armed_q == $past(armed_q));

endmodule

// File: rtl/keyed_wdog_core.sv
module keyed_wdog_core #(
    parameter int           W       = 32,
    parameter int unsigned  MIN_TO  = 256,
    parameter logic [W-1:0] CNT_RST = 32'h400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         irq_first,
    input  logic         inv_rst,
    input  logic         cnt_en,
    input  logic [W-1:0] tmo,
    input  logic         reload_req,
    input  logic         svc_bad,
    input  logic         flag_clr,
    output logic [W-1:0] count,
    output logic         irq,
    output logic         rst_req,
    output logic         bus_err
);

    localparam logic [W-1:0] MIN_V = W'(MIN_TO);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         flag;
        logic         rst;
        logic         berr;
    } core_t;

    core_t s_d, s_q;
    logic [W-1:0] eff_to;
    logic         expire;

    always_comb begin
        s_d    = s_q;
        s_d.berr = 1'b0;
        expire = 1'b0;
        eff_to = (tmo < MIN_V) ? MIN_V : tmo;
        if (flag_clr) s_d.flag = 1'b0;
        if (svc_bad) begin
            if (inv_rst) s_d.rst  = 1'b1;
            else         s_d.berr = 1'b1;
        end
        if (!s_q.rst) begin
            if (reload_req) begin
                s_d.cnt = eff_to;
            end else if (enable && cnt_en) begin
                if (s_q.cnt == '0) begin
                    expire = 1'b1;
                    if (irq_first && !s_q.flag) begin
                        s_d.flag = 1'b1;
                        s_d.cnt  = eff_to;
                    end else begin
                        s_d.rst = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= CNT_RST;
            s_q.flag <= 1'b0;
            s_q.rst  <= 1'b0;
            s_q.berr <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count   = s_q.cnt;
    assign irq     = s_q.flag;
    assign rst_req = s_q.rst;
    assign bus_err = s_q.berr;

    // R2: a load never places a value below the floor
    p_load_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req && !rst_req |=> count >= MIN_V);

    // R4: counter frozen without the strobe
    p_hold_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en && !reload_req |=> $stable(count));

    // R4: one step per enabled tick
    p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enable && cnt_en && count != '0 && !reload_req && !rst_req
        |=> count == $past(count) - W'(1));

    // R9: reset request is sticky
    p_rst_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R10: expiry with a pending flag ends in reset
    p_second_expiry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        expire && irq |=> rst_req);

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int           W      = 32,
    parameter int unsigned  MIN_TO = 256,
    parameter logic [W-1:0] TO_RST = 32'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_strap,
    input  logic              cnt_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              bus_err,
    output logic              irq,
    output logic              rst_req
);

    localparam logic [W-1:0] CNT_RST = (TO_RST < W'(MIN_TO)) ? W'(MIN_TO) : TO_RST;

    wd_ctrl_t         ctrl;
    logic [W-1:0]     tmo, win, count;
    logic             key_wr, en_rise, flag_clr;
    logic [KEY_W-1:0] key_val;
    logic             gate_closed, svc_ok, svc_bad;

    keyed_wdog_regs #(.W(W), .TO_RST(TO_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .en_strap(en_strap),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .count(count), .irq(irq), .bus_rdata(bus_rdata),
        .ctrl(ctrl), .tmo(tmo), .win(win),
        .key_wr(key_wr), .key_val(key_val), .en_rise(en_rise), .flag_clr(flag_clr)
    );

    assign gate_closed = ctrl.en && ctrl.win_mode && !(count < win);

    keyed_wdog_keyseq u_keys (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_val(key_val),
        .gate_closed(gate_closed), .svc_ok(svc_ok), .svc_bad(svc_bad)
    );

    keyed_wdog_core #(.W(W), .MIN_TO(MIN_TO), .CNT_RST(CNT_RST)) u_core (
        .clk(clk), .rst_n(rst_n), .enable(ctrl.en), .irq_first(ctrl.irq_first),
        .inv_rst(ctrl.inv_rst), .cnt_en(cnt_en), .tmo(tmo),
        .reload_req(en_rise | svc_ok), .svc_bad(svc_bad), .flag_clr(flag_clr),
        .count(count), .irq(irq), .rst_req(rst_req), .bus_err(bus_err)
    );

    // R7: a service key in a closed window does not touch a frozen count
    p_closed_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_KEY && ctrl.en && ctrl.win_mode && !(count < win)
        && (bus_wdata[KEY_W-1:0] == KEY_ARM || bus_wdata[KEY_W-1:0] == KEY_FIRE)
        && !cnt_en |=> $stable(count));

    // R12: the count register cannot be written
    p_cnt_readonly_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_CNT && !cnt_en |=> $stable(count));

endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_strap = 1'b0;
    logic          cnt_en = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic          bus_err, irq, rst_req;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    keyed_wdog #(.W(W), .MIN_TO(256), .TO_RST(32'h300)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_strap(en_strap), .cnt_en(cnt_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; en_strap = strap; cnt_en = 1'b0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic wait_for(input bit on_irq, output int n);
        n = 0;
        while ((on_irq ? irq : rst_req) !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset_state();
        logic [W-1:0] v;
        do_reset(1'b0);
        rd(3'd0, v); chk("R1 ctrl after reset", v, 32'h0);
        rd(3'd5, v); chk("R12 count after reset", v, 32'h300);
        chk("R9 no reset request", {31'b0, rst_req}, 32'h0);
        chk("R11 flag clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_strap();
        logic [W-1:0] v;
        do_reset(1'b1);
        rd(3'd0, v); chk("R1 strap run bit", v, 32'h1);
        tick(5);
        rd(3'd5, v); chk("R1 strap counts", v, 32'h300 - 5);
    endtask

    task automatic t_clamp_load();
        logic [W-1:0] v;
        do_reset(1'b0);
        wr(3'd1, 32'h20);
        wr(3'd0, 32'h1);
        rd(3'd5, v); chk("R2 clamp to 0x100", v, 32'h100);
        wr(3'd1, 32'h180);
        wr(3'd0, 32'h0);
        wr(3'd0, 32'h1);
        rd(3'd5, v); chk("R3 load on enable", v, 32'h180);
        wr(3'd0, 32'h0);
        tick(5);
        rd(3'd5, v); chk("R4 hold when stopped", v, 32'h180);
    endtask

    task automatic t_service();
        logic [W-1:0] v;
        do_reset(1'b0);
        wr(3'd1, 32'h200);
        wr(3'd0, 32'h1);
        tick(10);
        rd(3'd5, v); chk("R4 ten steps", v, 32'h1F6);
        wr(3'd3, 32'hA602);
        wr(3'd3, 32'hC520);
        wr(3'd3, 32'hD928);
        repeat (4) @(negedge clk);
        rd(3'd5, v); chk("R6 unlock keys no reload", v, 32'h1F6);
        wr(3'd3, 32'hB480);
        rd(3'd5, v); chk("R5 sequence reloads", v, 32'h200);
        tick(10);
        wr(3'd3, 32'hA602);
        wr(3'd3, 32'h1234);
        wr(3'd3, 32'hB480);
        rd(3'd5, v); chk("R6 other key cancels", v, 32'h1F6);
        wr(3'd3, 32'hB480);
        rd(3'd5, v); chk("R6 lone second key", v, 32'h1F6);
        wr(3'd3, 32'hA602);
        wr(3'd3, 32'hA602);
        wr(3'd3, 32'hB480);
        rd(3'd5, v); chk("R6 rearm then fire", v, 32'h200);
        wr(3'd5, 32'h42);
        rd(3'd5, v); chk("R12 count read-only", v, 32'h200);
    endtask

    task automatic t_timeout_reset();
        int n;
        do_reset(1'b0);
        wr(3'd1, 32'h100);
        cnt_en = 1'b1;
        wr(3'd0, 32'h1);
        wait_for(1'b0, n);
        chk("R9 expiry tick count", n, 257);
        repeat (20) @(negedge clk);
        chk("R9 request sticky", {31'b0, rst_req}, 32'h1);
        cnt_en = 1'b0;
    endtask

    task automatic t_irq_first();
        logic [W-1:0] v;
        int n;
        do_reset(1'b0);
        wr(3'd1, 32'h100);
        cnt_en = 1'b1;
        wr(3'd0, 32'h9);
        wait_for(1'b1, n);
        chk("R10 first expiry timing", n, 257);
        chk("R10 no reset on first", {31'b0, rst_req}, 32'h0);
        rd(3'd5, v); chk("R10 reload on first", v, 32'h100);
        wait_for(1'b0, n);
        chk("R10 second expiry resets", n, 257);
        cnt_en = 1'b0;
    endtask

    task automatic t_irq_clear();
        logic [W-1:0] v;
        int n;
        do_reset(1'b0);
        wr(3'd1, 32'h100);
        cnt_en = 1'b1;
        wr(3'd0, 32'h9);
        wait_for(1'b1, n);
        wr(3'd4, 32'h0);
        rd(3'd4, v); chk("R11 write 0 keeps flag", v, 32'h1);
        wr(3'd4, 32'h1);
        rd(3'd4, v); chk("R11 write 1 clears", v, 32'h0);
        wait_for(1'b1, n);
        chk("R11 flag raised again", {31'b0, irq}, 32'h1);
        chk("R10 cleared flag means no reset", {31'b0, rst_req}, 32'h0);
        cnt_en = 1'b0;
    endtask

    task automatic t_window();
        logic [W-1:0] v;
        do_reset(1'b0);
        wr(3'd1, 32'h100);
        wr(3'd2, 32'h80);
        wr(3'd0, 32'h3);
        wr(3'd3, 32'hA602);
        chk("R8 bus error pulse", {31'b0, bus_err}, 32'h1);
        @(negedge clk);
        chk("R8 bus error one cycle", {31'b0, bus_err}, 32'h0);
        wr(3'd3, 32'hB480);
        rd(3'd5, v); chk("R7 closed window no reload", v, 32'h100);
        tick(32'h90);
        wr(3'd3, 32'hA602);
        wr(3'd3, 32'hB480);
        rd(3'd5, v); chk("R7 open window reload", v, 32'h100);
        chk("R7 no error inside window", {31'b0, bus_err}, 32'h0);
        wr(3'd0, 32'h7);
        wr(3'd3, 32'hA602);
        chk("R8 misuse requests reset", {31'b0, rst_req}, 32'h1);
        chk("R8 no bus error in reset mode", {31'b0, bus_err}, 32'h0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errs++; checks++;
                $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
                $display("Result: errors=%0d of %0d checks", errs, checks);
                $finish;
            end
        end
    end

    initial begin
        t_reset_state();
        t_strap();
        t_clamp_load();
        t_service();
        t_timeout_reset();
        t_irq_first();
        t_irq_clear();
        t_window();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule